// File: doc/BRIEF.md
# Host controller run/halt/reset control

This block holds the command and status control of a host controller that executes a bus schedule. Software reaches it through a simple register write and read port. One writable bit starts and stops the schedule. A second writable bit starts a self-clearing reset sequence of the controller. A read-only field reports the supported frame list size. The block drives a halted status flag, a level that allows the schedule engine to run, and a level that makes the engine abandon its current transaction.

Stopping is graceful. When software clears the run bit, the block waits until the transaction engine reports that the transaction on the bus has completed, and only then does the halted flag rise. A failed memory read reported by the engine stops the controller in the same way. The reset sequence runs for a fixed, parameterised number of cycles and cannot be cut short. While it runs, the engine is held in abort and software writes are ignored. At the start of the sequence the block sends a one-cycle request that returns port ownership to the companion controller. Writing the reset bit while the controller is not halted is undefined behaviour, so the block flags it on a debug output and still performs the reset.

Top module: `hc_runctl`

## Requirements
- R1: After hardware reset, rd_data reads all zero and halted is 1. Bit positions in rd_data are fixed: bit 0 is the run bit, bit 1 reads 1 while a reset sequence is in progress, and bits 3:2 are the frame list size code. That code always reads 00, which means 1024 entries. Any bits above bit 3 read 0.
- R2: When halted is 1 and mem_err is 0, a write with wr_cmd[0]=1 and wr_cmd[1]=0 gives run=1, halted=0 and sched_go=1, all in the cycle after the write.
- R3: When running, a write with wr_cmd=00 in a cycle where xact_busy=0 gives run=0 and halted=1 in the next cycle.
- R4: When running, a stop in a cycle where xact_busy=1 and xact_done=0 gives run=0 and halted=0 (halting). halted stays 0 until the cycle after xact_done is 1, and becomes 1 then.
- R5: run=1 together with halted=1 is never observed.
- R6: When no reset is in progress, mem_err=1 clears the run bit in the next cycle, and the controller halts as in R3 and R4. In the cycle mem_err is 1, a write of run=1 has no effect.
- R7: A write with wr_cmd[1]=1 gives, in the next cycle, reset bit=1, run=0, halted=1 and eng_abort=1. ports_to_comp is 1 for that one cycle only. The reset bit reads 1 for exactly RST_CYCLES cycles and then clears by itself.
- R8: While a reset is in progress, every write is ignored. Writing run=1 leaves run at 0, and writing 0 to the reset bit does not end the sequence early.
- R9: When the reset sequence ends, run=0 and halted=1. The next write of run=1 is accepted as in R2.
- R10: dbg_rst_err is 1 for one cycle, the cycle after a reset write, if halted was 0 when the write was made. Otherwise it stays 0.
- R11: A write with both bits set (wr_cmd=11) is treated as a reset. run stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Command register write strobe |
| wr_cmd | input | 2 | Write data: bit 0 run, bit 1 controller reset |
| rd_data | output | CMD_W | Command register read value |
| halted | output | 1 | Halted status flag |
| sched_go | output | 1 | Schedule engine may execute |
| xact_busy | input | 1 | A bus transaction is in flight |
| xact_done | input | 1 | The in-flight transaction completes this cycle |
| mem_err | input | 1 | A memory read completed with a failing status |
| eng_abort | output | 1 | Engine must drop its transaction; high during reset |
| ports_to_comp | output | 1 | One-cycle request to return port ownership to the companion |
| dbg_rst_err | output | 1 | Reset was written while the controller was not halted |

## Verification
Every state register in this block is visible at the ports one cycle after it changes. A wrong run/halt state therefore shows up at once on rd_data bit 0, halted or sched_go, in the cycle after the stimulus that caused it. A reset counter that is off by one shows on the cycle in which rd_data bit 1 and eng_abort fall. The most delicate case is a stop while a transaction is in flight: halted that rises early or late is caught on the exact cycle after xact_done. Writes during a reset are checked by watching the run bit stay 0 for the whole window.

// File: rtl/hc_runctl_pkg.sv
package hc_runctl_pkg;
   typedef enum logic [1:0] {
      ST_HALTED  = 2'd0,
      ST_RUNNING = 2'd1,
      ST_HALTING = 2'd2
   } hc_state_e;

   localparam int BIT_RUN = 0;
   localparam int BIT_RST = 1;
   localparam int FLS_LO  = 2;
   localparam int FLS_HI  = 3;
   localparam logic [1:0] FLS_1024 = 2'b00;
endpackage

// File: rtl/hc_rst_seq.sv
module hc_rst_seq #(
   parameter int RST_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam int LEN_W = $clog2(RST_CYCLES + 2);

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("hc_rst_seq: RST_CYCLES must be at least 1");
   end

   if (RST_CYCLES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy <= 1'b0;
         else        busy <= start;
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(RST_CYCLES - 1);
         end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
         end
      end
   end

   logic [LEN_W-1:0] len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    len_q <= '0;
      else if (busy) len_q <= len_q + 1'b1;
      else           len_q <= '0;
   end

   AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (len_q == LEN_W'(RST_CYCLES))); // R7
   AST_RST_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R7
endmodule

// File: rtl/hc_run_fsm.sv
module hc_run_fsm
   import hc_runctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rst_req,
   input  logic rst_busy,
   input  logic run_set,
   input  logic run_clr,
   input  logic mem_err,
   input  logic xact_busy,
   input  logic xact_done,
   output logic run_q,
   output logic halted
);
   hc_state_e state;
   logic      stop_now;
   logic      start_ok;
   logic      drain;

   assign stop_now = mem_err | run_clr;
   assign start_ok = run_set & ~mem_err;
   assign drain    = xact_busy & ~xact_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HALTED;
         run_q <= 1'b0;
      end else if (rst_req || rst_busy) begin
         state <= ST_HALTED;
         run_q <= 1'b0;
      end else begin
         case (state)
            ST_RUNNING: begin
               if (stop_now) begin
                  run_q <= 1'b0;
                  state <= drain ? ST_HALTING : ST_HALTED;
               end
            end
            ST_HALTING: begin
               if (start_ok) begin
                  run_q <= 1'b1;
                  state <= ST_RUNNING;
               end else if (xact_done) begin
                  state <= ST_HALTED;
               end
            end
            default: begin
               if (start_ok) begin
                  run_q <= 1'b1;
                  state <= ST_RUNNING;
               end
            end
         endcase
      end
   end

   assign halted = (state == ST_HALTED);

   AST_NO_RUN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_q && halted)); // R5
   AST_START_CLEARS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && start_ok && !rst_req && !rst_busy) |=> (run_q && !halted)); // R2
   AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && run_clr && !xact_busy) |=> halted); // R3
   AST_HALT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALTING && !xact_done && !start_ok && !rst_req) |=> !halted); // R4
   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_err && !rst_busy) |=> !run_q); // R6
   AST_IGNORE_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      rst_busy |=> (!run_q && halted)); // R8
endmodule

// File: rtl/hc_cmd_view.sv
module hc_cmd_view
   import hc_runctl_pkg::*;
#(
   parameter int CMD_W = 4
) (
   input  logic             run_q,
   input  logic             rst_busy,
   output logic [CMD_W-1:0] rd_data
);
   if (CMD_W < FLS_HI + 1) begin : g_bad_width
      $error("hc_cmd_view: CMD_W must hold the frame list size field");
   end

   always_comb begin
      rd_data                 = '0;
      rd_data[BIT_RUN]        = run_q;
      rd_data[BIT_RST]        = rst_busy;
      rd_data[FLS_HI:FLS_LO]  = FLS_1024;
   end
endmodule

// File: rtl/hc_runctl.sv
module hc_runctl
   import hc_runctl_pkg::*;
#(
   parameter int CMD_W      = 4,
   parameter int RST_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_cmd,
   output logic [CMD_W-1:0] rd_data,
   output logic             halted,
   output logic             sched_go,
   input  logic             xact_busy,
   input  logic             xact_done,
   input  logic             mem_err,
   output logic             eng_abort,
   output logic             ports_to_comp,
   output logic             dbg_rst_err
);
   logic rst_busy;
   logic rst_req;
   logic wr_ok;
   logic run_set;
   logic run_clr;
   logic run_q;

   assign rst_req = wr_en & wr_cmd[BIT_RST] & ~rst_busy;
   assign wr_ok   = wr_en & ~wr_cmd[BIT_RST] & ~rst_busy;
   assign run_set = wr_ok &  wr_cmd[BIT_RUN];
   assign run_clr = wr_ok & ~wr_cmd[BIT_RUN];

   hc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rst_req),
      .busy  (rst_busy)
   );

   hc_run_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_req   (rst_req),
      .rst_busy  (rst_busy),
      .run_set   (run_set),
      .run_clr   (run_clr),
      .mem_err   (mem_err),
      .xact_busy (xact_busy),
      .xact_done (xact_done),
      .run_q     (run_q),
      .halted    (halted)
   );

   hc_cmd_view #(.CMD_W(CMD_W)) u_view (
      .run_q    (run_q),
      .rst_busy (rst_busy),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ports_to_comp <= 1'b0;
         dbg_rst_err   <= 1'b0;
      end else begin
         ports_to_comp <= rst_req;
         dbg_rst_err   <= rst_req & ~halted;
      end
   end

   assign sched_go  = run_q;
   assign eng_abort = rst_busy;

   AST_POST_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_busy) |-> (halted && !run_q)); // R9
   AST_DBG_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_rst_err |-> (rst_busy && halted)); // R10
   AST_COMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ports_to_comp |=> !ports_to_comp); // R7
endmodule

// File: tb/hc_runctl_test.sv
module hc_runctl_test;
   localparam int RSTC = 8;
   localparam int CMDW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_cmd = 2'b00;
   logic [CMDW-1:0] rd_data;
   logic            halted, sched_go, eng_abort, ports_to_comp, dbg_rst_err;
   logic            xact_busy = 1'b0, xact_done = 1'b0, mem_err = 1'b0;

   hc_runctl #(.CMD_W(CMDW), .RST_CYCLES(RSTC)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
      .rd_data(rd_data), .halted(halted), .sched_go(sched_go),
      .xact_busy(xact_busy), .xact_done(xact_done), .mem_err(mem_err),
      .eng_abort(eng_abort), .ports_to_comp(ports_to_comp),
      .dbg_rst_err(dbg_rst_err)
   );

   int total = 0;
   int bad   = 0;

   bit m_run = 1'b0, m_halted = 1'b1, m_dbg = 1'b0, m_comp = 1'b0;
   int m_rcnt = 0;

   task automatic chk(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model(bit we, bit [1:0] wd, bit xb, bit xd, bit er);
      bit set, clr;
      if (m_rcnt > 0) begin
         m_rcnt--; m_dbg = 0; m_comp = 0;
      end else if (we && wd[1]) begin
         m_dbg = !m_halted; m_comp = 1; m_rcnt = RSTC; m_run = 0; m_halted = 1;
      end else begin
         m_dbg = 0; m_comp = 0;
         set = we && wd[0] && !er;
         clr = we && !wd[0];
         if (m_run) begin
            if (er || clr) begin
               m_run = 0;
               m_halted = !(xb && !xd);
            end
         end else if (set) begin
            m_run = 1; m_halted = 0;
         end else if (!m_halted && xd) begin
            m_halted = 1;
         end
      end
   endtask

   task automatic compare_all(string tag);
      chk(tag, "run", int'(rd_data[0]), int'(m_run));
      chk(tag, "sched_go", int'(sched_go), int'(m_run));
      chk(tag, "halted", int'(halted), int'(m_halted));
      chk(tag, "reset_bit", int'(rd_data[1]), int'(m_rcnt > 0));
      chk(tag, "eng_abort", int'(eng_abort), int'(m_rcnt > 0));
      chk(tag, "dbg_rst_err", int'(dbg_rst_err), int'(m_dbg));
      chk(tag, "ports_to_comp", int'(ports_to_comp), int'(m_comp));
      chk("R1", "frame_size", int'(rd_data[3:2]), 0);
      chk("R5", "run_and_halted", int'(rd_data[0] & halted), 0);
   endtask

   task automatic step(string tag, bit we, bit [1:0] wd, bit xb, bit xd, bit er);
      @(negedge clk);
      wr_en = we; wr_cmd = wd; xact_busy = xb; xact_done = xd; mem_err = er;
      model(we, wd, xb, xd, er);
      @(posedge clk);
      #1;
      compare_all(tag);
   endtask

   task automatic idle(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 2'b00, 0, 0, 0);
   endtask

   initial begin
      #(4 * 200000);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'h5eed);
      repeat (3) @(posedge clk);
      #1;
      compare_all("R1");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1", 2);

      step("R2", 1, 2'b01, 0, 0, 0);
      idle("R2", 2);
      step("R3", 1, 2'b00, 0, 0, 0);
      idle("R3", 1);

      step("R2", 1, 2'b01, 0, 0, 0);
      step("R4", 1, 2'b00, 1, 0, 0);
      for (int i = 0; i < 3; i++) step("R4", 0, 2'b00, 1, 0, 0);
      step("R4", 0, 2'b00, 1, 1, 0);
      idle("R4", 1);

      step("R2", 1, 2'b01, 0, 0, 0);
      step("R6", 0, 2'b00, 1, 0, 1);
      step("R6", 0, 2'b00, 1, 0, 0);
      step("R6", 0, 2'b00, 0, 1, 0);
      step("R6", 1, 2'b01, 0, 0, 1);
      step("R6", 1, 2'b01, 0, 0, 0);
      step("R6", 0, 2'b00, 0, 0, 1);
      idle("R6", 1);

      step("R2", 1, 2'b01, 0, 0, 0);
      step("R10", 1, 2'b10, 1, 0, 0);
      for (int i = 0; i < RSTC + 2; i++)
         step("R8", 1, (i % 2 == 0) ? 2'b01 : 2'b00, 1, 0, 0);
      step("R9", 1, 2'b01, 0, 0, 0);
      step("R9", 1, 2'b00, 0, 0, 0);

      step("R10", 1, 2'b10, 0, 0, 0);
      idle("R7", RSTC + 1);
      step("R11", 1, 2'b11, 0, 0, 0);
      idle("R11", RSTC + 1);

      for (int i = 0; i < 3000; i++) begin
         bit we, xb, xd, er;
         bit [1:0] wd;
         we = ($urandom % 6) == 0;
         wd[0] = $urandom % 2;
         wd[1] = ($urandom % 20) == 0;
         xb = $urandom % 2;
         xd = ($urandom % 4) == 0;
         er = ($urandom % 40) == 0;
         step("R5", we, wd, xb, xd, er);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule